// File: doc/BRIEF.md
# Radio Receive Byte Queue with Sticky Overflow

This block buffers received bytes between a packet radio's demodulator and the host. Storage is a 64-entry byte queue, and a single prefetch register sits in front of the host read port. The prefetch register always holds the oldest unread byte, so the total capacity is 65 unread bytes. The radio side presents one byte per cycle with a write enable. The host sees the byte at the head together with a valid flag, and takes it with a read enable.

A three-state receive controller runs the write side. In idle, incoming bytes are dropped. A receive strobe opens reception. A byte that arrives when all 65 places are taken sends the controller into a locked overflow state. That state discards traffic until an idle strobe is given, and a later flush strobe empties the queue.

The controller also tracks packet framing so that it can drive a packet-in-progress output. In variable mode the first byte of a packet is its payload length. In fixed mode the programmed length is used. Two appended status bytes are optionally counted on top. The CRC enable input is accepted, but it has no effect on buffering or on the overflow behaviour.

Top module: `rfq_rx_buffer`

## Requirements
- R1: The `level` output equals the number of unread bytes: bytes accepted minus bytes popped. It ranges from 0 to 65 (64 in storage plus one in the prefetch register) and is 0 after reset.
- R2: Bytes leave in arrival order. `rd_valid` high means `rd_data` holds the oldest byte, and a pop occurs on a clock edge where `rd_en` and `rd_valid` are both high. A byte written into an empty queue becomes valid after the second clock edge following its write. While more bytes are queued, the next byte is valid in the cycle after a pop, so holding `rd_en` high drains one byte per cycle.
- R3: A write in the receive state while `level` is 65, with no pop on the same edge, moves the controller to the overflow state and the byte is discarded. If a pop occurs on the same edge, the byte is accepted and no overflow occurs.
- R4: In the overflow state, writes and receive strobes are ignored, and `level` does not rise.
- R5: `pkt_busy` falls on the edge that enters overflow. This holds for every combination of `cfg_append` and `cfg_crc_en`.
- R6: `overflow` is high exactly while the controller is in the overflow state. Only an idle strobe leaves that state, and it leads to idle. The contents are kept.
- R7: A flush strobe in idle empties the storage and the prefetch register, so `level` becomes 0 and `rd_valid` becomes 0 on the next edge. A flush strobe in the receive or overflow state is ignored.
- R8: Writes are accepted only in the receive state. In idle they are dropped. A receive strobe in idle enters the receive state, and an idle strobe takes priority over any write on the same edge.
- R9: Packet length in bytes is L+1 in variable mode, where the first byte is the length byte with value L. It is `cfg_pkt_len` in fixed mode. Either length is increased by 2 when `cfg_append` is 1. `pkt_busy` rises with the first byte of a packet whose length is more than 1, and falls with its last byte.
- R10: A variable-mode packet with L=61 plus status bytes, and a fixed-mode packet of 62 plus status bytes, each fill 64 places exactly, with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_rx | input | 1 | Strobe that opens reception from idle |
| cmd_idle | input | 1 | Strobe that returns the controller to idle |
| cmd_flush | input | 1 | Strobe that empties the queue (idle only) |
| cfg_append | input | 1 | Two status bytes follow each payload |
| cfg_crc_en | input | 1 | CRC enable; no effect on buffering |
| cfg_var_len | input | 1 | 1 = variable length (first byte is length), 0 = fixed |
| cfg_pkt_len | input | 8 | Programmed packet length in fixed mode |
| wr_en | input | 1 | Received byte valid |
| wr_data | input | 8 | Received byte |
| rd_en | input | 1 | Host pop request |
| rd_data | output | 8 | Oldest unread byte |
| rd_valid | output | 1 | `rd_data` holds a byte |
| level | output | 7 | Unread byte count, 0 to 65 |
| overflow | output | 1 | Controller is in the overflow state |
| pkt_busy | output | 1 | A packet is being received |

## Verification
The bench targets the 65-byte boundary. It checks that the 66th byte locks the controller, and that a write paired with a pop at that level does not. A design that counted only the storage would lock one byte early. A design that ignored the same-edge pop would lock on a legal write. In overflow, the bench checks that further writes, receive strobes and early flushes leave the count and the data untouched, and that `pkt_busy` drops with status bytes and CRC enabled. A design stuck in a receive-like state would keep the indicator high and keep counting. The bench sweeps every fixed length and every variable length byte up to the 64-byte limit. It reads back each byte in order at one byte per cycle, so a refill bubble or a misframed packet end would show up as a wrong byte or a wrong busy edge.

// File: rtl/rfq_pkg.sv
package rfq_pkg;

  localparam int BYTE_W    = 8;
  localparam int STATUS_N  = 2;

  typedef enum logic [1:0] {
    RFQ_IDLE = 2'd0,
    RFQ_RX   = 2'd1,
    RFQ_OVF  = 2'd2
  } rfq_state_e;

  // Total bytes occupied by one packet, never less than one.
  function automatic logic [8:0] pkt_total(
    input logic              var_mode,
    input logic              append,
    input logic [BYTE_W-1:0] cfg_len,
    input logic [BYTE_W-1:0] first_byte
  );
    logic [8:0] base;
    logic [8:0] tot;
    base = var_mode ? ({1'b0, first_byte} + 9'd1) : {1'b0, cfg_len};
    tot  = base + (append ? 9'(STATUS_N) : 9'd0);
    if (tot == 9'd0) tot = 9'd1;
    return tot;
  endfunction

endpackage

// File: rtl/rfq_store.sv
module rfq_store #(
  parameter int DEPTH = 64,
  parameter int W     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic                         take,
  input  logic                         clr,
  input  logic [W-1:0]                 din,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   cnt
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp;
  logic [AW-1:0] rp;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (take) rp <= bump(rp);
      cnt <= cnt + CW'(push) - CW'(take);
    end
  end

  assign head = mem[rp];

endmodule

// File: rtl/rfq_prefetch.sv
module rfq_prefetch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      dout  <= '0;
    end else if (clr) begin
      valid <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      dout  <= din;
    end else if (pop) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rfq_ctrl.sv
module rfq_ctrl
  import rfq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_rx,
  input  logic              cmd_idle,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              full_all,
  input  logic              pop_ok,
  input  logic              cfg_var_len,
  input  logic              cfg_append,
  input  logic [BYTE_W-1:0] cfg_pkt_len,
  output rfq_state_e        st,
  output logic              push_ok,
  output logic              ovf_evt,
  output logic              busy
);
  logic       live_wr;
  logic       start_evt;
  logic [8:0] rem;
  logic [8:0] rem_nx;

  assign live_wr   = (st == RFQ_RX) && wr_en && !cmd_idle;
  assign ovf_evt   = live_wr && full_all && !pop_ok;
  assign push_ok   = live_wr && !(full_all && !pop_ok);
  assign start_evt = (st == RFQ_IDLE) && cmd_rx && !cmd_idle;

  always_comb begin
    if (!busy) rem_nx = pkt_total(cfg_var_len, cfg_append, cfg_pkt_len, wr_data) - 9'd1;
    else       rem_nx = rem - 9'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= RFQ_IDLE;
    end else if (cmd_idle) begin
      st <= RFQ_IDLE;
    end else if (start_evt) begin
      st <= RFQ_RX;
    end else if (ovf_evt) begin
      st <= RFQ_OVF;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || cmd_idle || start_evt || ovf_evt) begin
      busy <= 1'b0;
      rem  <= '0;
    end else if (push_ok) begin
      rem  <= rem_nx;
      busy <= (rem_nx != 9'd0);
    end
  end

endmodule

// File: rtl/rfq_rx_buffer.sv
module rfq_rx_buffer
  import rfq_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_rx,
  input  logic        cmd_idle,
  input  logic        cmd_flush,
  input  logic        cfg_append,
  input  logic        cfg_crc_en,
  input  logic        cfg_var_len,
  input  logic [7:0]  cfg_pkt_len,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  input  logic        rd_en,
  output logic [7:0]  rd_data,
  output logic        rd_valid,
  output logic [$clog2(DEPTH+2)-1:0] level,
  output logic        overflow,
  output logic        pkt_busy
);
  localparam int CW  = $clog2(DEPTH+1);
  localparam int LW  = $clog2(DEPTH+2);
  localparam int CAP = DEPTH + 1;

  rfq_state_e        st;
  logic              push_ok;
  logic              ovf_evt;
  logic              flush_ok;
  logic              pop_ok;
  logic              move_evt;
  logic              full_all;
  logic [CW-1:0]     s_cnt;
  logic [BYTE_W-1:0] s_head;
  logic              crc_cfg_unused;

  // CRC checking happens upstream; the setting has no effect here.
  assign crc_cfg_unused = cfg_crc_en;

  assign flush_ok = cmd_flush && (st == RFQ_IDLE);
  assign pop_ok   = rd_en && rd_valid && !flush_ok;
  assign move_evt = (s_cnt != '0) && (!rd_valid || pop_ok) && !flush_ok;
  assign level    = LW'(s_cnt) + LW'(rd_valid);
  assign full_all = (level == LW'(CAP));
  assign overflow = (st == RFQ_OVF);

  rfq_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_rx      (cmd_rx),
    .cmd_idle    (cmd_idle),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .full_all    (full_all),
    .pop_ok      (pop_ok),
    .cfg_var_len (cfg_var_len),
    .cfg_append  (cfg_append),
    .cfg_pkt_len (cfg_pkt_len),
    .st          (st),
    .push_ok     (push_ok),
    .ovf_evt     (ovf_evt),
    .busy        (pkt_busy)
  );

  rfq_store #(.DEPTH(DEPTH), .W(BYTE_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push_ok),
    .take  (move_evt),
    .clr   (flush_ok),
    .din   (wr_data),
    .head  (s_head),
    .cnt   (s_cnt)
  );

  rfq_prefetch #(.W(BYTE_W)) u_pf (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (flush_ok),
    .load  (move_evt),
    .pop   (pop_ok),
    .din   (s_head),
    .dout  (rd_data),
    .valid (rd_valid)
  );

endmodule

// File: rtl/rfq_checker.sv
module rfq_checker
  import rfq_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_en,
  input logic                       rd_en,
  input logic                       cmd_idle,
  input logic                       cmd_flush,
  input logic                       rd_valid,
  input logic [$clog2(DEPTH+2)-1:0] level,
  input logic                       overflow,
  input logic                       pkt_busy,
  input rfq_state_e                 st,
  input logic                       ovf_evt,
  input logic                       push_ok
);
  localparam int CAP = DEPTH + 1;

  a_r1_level_cap: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level) <= CAP);

  a_r2_stream: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_valid && int'(level) >= 2) |=> rd_valid);

  a_r3_ovf_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> ($past(int'(level)) == CAP && $past(wr_en)));

  a_r3_event_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_evt && push_ok));

  a_r4_ovf_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !rd_en) |=> $stable(level));

  a_r5_busy_low: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> !pkt_busy);

  a_r6_exit_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(overflow) |-> ($past(cmd_idle) && st == RFQ_IDLE));

  a_r7_flush_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RFQ_IDLE && cmd_flush) |=> (level == '0 && !rd_valid));

  a_r7_flush_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (st != RFQ_IDLE && !rd_en) |=> (level >= $past(level)));

  a_r8_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RFQ_IDLE && !rd_en && !cmd_flush) |=> $stable(level));

endmodule

bind rfq_rx_buffer rfq_checker #(.DEPTH(DEPTH)) u_rfq_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .cmd_idle  (cmd_idle),
  .cmd_flush (cmd_flush),
  .rd_valid  (rd_valid),
  .level     (level),
  .overflow  (overflow),
  .pkt_busy  (pkt_busy),
  .st        (st),
  .ovf_evt   (ovf_evt),
  .push_ok   (push_ok)
);

// File: tb/rfq_rx_buffer_bench.sv
module rfq_rx_buffer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_rx = 0, cmd_idle = 0, cmd_flush = 0;
  logic       cfg_append = 0, cfg_crc_en = 0, cfg_var_len = 0;
  logic [7:0] cfg_pkt_len = 8'd0;
  logic       wr_en = 0, rd_en = 0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       rd_valid;
  logic [6:0] level;
  logic       overflow, pkt_busy;

  always #5 clk = ~clk;

  rfq_rx_buffer u_rfq_rx_buffer (
    .clk(clk), .rst_n(rst_n), .cmd_rx(cmd_rx), .cmd_idle(cmd_idle),
    .cmd_flush(cmd_flush), .cfg_append(cfg_append), .cfg_crc_en(cfg_crc_en),
    .cfg_var_len(cfg_var_len), .cfg_pkt_len(cfg_pkt_len), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .level(level), .overflow(overflow), .pkt_busy(pkt_busy)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [7:0] model [0:1023];
  int mh = 0;
  int mt = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic put(input logic [7:0] b, input bit keep);
    wr_en = 1; wr_data = b;
    tick();
    wr_en = 0;
    if (keep) begin model[mt % 1024] = b; mt++; end
  endtask

  task automatic s_rx();    cmd_rx = 1;    tick(); cmd_rx = 0;    endtask
  task automatic s_idle();  cmd_idle = 1;  tick(); cmd_idle = 0;  endtask
  task automatic s_flush(); cmd_flush = 1; tick(); cmd_flush = 0; mh = mt; endtask

  task automatic drain(input string req);
    tick();
    while (mt > mh) begin
      check(req, int'(rd_valid), 1);
      check(req, int'(rd_data), int'(model[mh % 1024]));
      rd_en = 1;
      tick();
      mh++;
    end
    rd_en = 0;
    check(req, int'(rd_valid), 0);
    check(req, int'(level), 0);
  endtask

  task automatic send_pkt(input bit vm, input bit app, input int len, input int seed);
    int total;
    logic [7:0] b;
    total = (vm ? len + 1 : len) + (app ? 2 : 0);
    for (int i = 0; i < total; i++) begin
      b = (vm && i == 0) ? 8'(len) : 8'((i * 37 + seed) & 255);
      put(b, 1);
      if (i < total - 1) check("R9 busy inside packet", int'(pkt_busy), 1);
      else               check("R9 busy after last byte", int'(pkt_busy), 0);
    end
    check("R1 level equals packet size", int'(level), total);
    check("R10 no overflow within 64", int'(overflow), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    check("R1 reset level", int'(level), 0);
    check("R2 reset valid", int'(rd_valid), 0);
    check("R6 reset overflow", int'(overflow), 0);
    check("R9 reset busy", int'(pkt_busy), 0);

    // R8: writes in idle are dropped
    for (int i = 0; i < 3; i++) put(8'(i + 5), 0);
    tick();
    check("R8 idle writes dropped", int'(level), 0);
    check("R8 idle writes dropped valid", int'(rd_valid), 0);

    // R2 latency and R7 flush ignored in RX
    s_rx();
    put(8'h3C, 1);
    check("R2 not valid after one edge", int'(rd_valid), 0);
    tick();
    check("R2 valid after second edge", int'(rd_valid), 1);
    put(8'h3D, 1); put(8'h3E, 1);
    cmd_flush = 1; tick(); cmd_flush = 0;
    check("R7 flush ignored in RX", int'(level), 3);
    drain("R2 order after ignored flush");
    s_idle();

    // Sweeps over fixed and variable lengths
    for (int app = 0; app < 2; app++) begin
      cfg_append = 1'(app);
      cfg_var_len = 0;
      for (int n = 1; n <= 64 - 2 * app; n++) begin
        cfg_pkt_len = 8'(n);
        s_rx();
        send_pkt(0, 1'(app), n, n + app);
        drain(n == 62 ? "R10 fixed 62 readback" : "R2 fixed readback");
        s_idle();
      end
      cfg_var_len = 1;
      for (int n = 0; n <= 63 - 2 * app; n++) begin
        s_rx();
        send_pkt(1, 1'(app), n, 3 * n);
        drain(n == 61 ? "R10 variable 61 readback" : "R9 variable readback");
        s_idle();
      end
    end

    // Overflow lock, with status and CRC on and off
    for (int crc = 0; crc < 2; crc++) begin
      cfg_crc_en = 1'(crc); cfg_append = 1; cfg_var_len = 1;
      s_rx();
      put(8'd255, 1);
      for (int i = 0; i < 64; i++) put(8'(i * 11 + crc), 1);
      check("R1 full at 65", int'(level), 65);
      check("R3 no overflow at 65", int'(overflow), 0);
      check("R9 busy before overflow", int'(pkt_busy), 1);
      put(8'hEE, 0);
      check("R3 overflow on 66th", int'(overflow), 1);
      check("R5 busy drops on overflow", int'(pkt_busy), 0);
      check("R3 extra byte discarded", int'(level), 65);
      for (int i = 0; i < 3; i++) put(8'hDD, 0);
      check("R4 writes ignored in overflow", int'(level), 65);
      cmd_flush = 1; tick(); cmd_flush = 0;
      check("R7 flush ignored in overflow", int'(level), 65);
      check("R6 still overflow after flush", int'(overflow), 1);
      s_rx();
      check("R4 rx strobe ignored", int'(overflow), 1);
      s_idle();
      check("R6 idle leaves overflow", int'(overflow), 0);
      check("R6 contents kept", int'(level), 65);
      if (crc == 0) begin
        drain("R3 kept bytes in order");
      end else begin
        s_flush();
        check("R7 flush empties", int'(level), 0);
        check("R7 flush clears valid", int'(rd_valid), 0);
      end
    end

    // Write with simultaneous pop at capacity
    cfg_var_len = 0; cfg_append = 0; cfg_pkt_len = 8'd200;
    s_rx();
    for (int i = 0; i < 65; i++) put(8'(i ^ 8'h5A), 1);
    check("R1 at capacity", int'(level), 65);
    check("R3 head before pop", int'(rd_data), int'(model[mh % 1024]));
    wr_en = 1; wr_data = 8'hAB; rd_en = 1;
    tick();
    wr_en = 0; rd_en = 0; mh++;
    model[mt % 1024] = 8'hAB; mt++;
    check("R3 pop makes room", int'(overflow), 0);
    check("R3 level with pop", int'(level), 65);
    check("R2 next head after pop", int'(rd_data), int'(model[mh % 1024]));
    put(8'h11, 0);
    check("R3 overflow without pop", int'(overflow), 1);
    s_idle();
    s_flush();
    check("R7 final flush", int'(level), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule